// File: doc/BRIEF.md
# Selectable SDRAM Refresh Timer

This block paces refreshes for an SDRAM controller. A two-bit rate code picks one of three refresh intervals, or it switches refresh off. The core clock frequency is a build parameter. The block turns each interval into a whole number of clock cycles by multiplying the interval by the frequency and rounding down. For example, 7.8 µs at 133 MHz gives 1037 cycles. The memory clock is meant to equal the processor bus clock of 66, 100 or 133 MHz.

When an interval expires, the block adds one refresh to a small pending count. The request output stays high while that count is nonzero. The controller pulses the acknowledge input once for each refresh it has issued, and each pulse removes one refresh from the count. If the controller falls behind, refreshes build up in the count up to a ceiling of eight. A new rate code starts the interval from zero, so the next request comes one full new interval after the change.

Top module: `refresh_timer`

## Requirements
- R1: While reset is asserted, and right after it is released, `refresh_req` is 0 and `pend_cnt` is 0.
- R2: Rate code 2'b00 turns refresh off. No interval expires, and no request is added, however long the code is held.
- R3: Rate code 2'b01 sets an interval of floor(7800 × CLK_MHZ / 1000) cycles (7.8 µs). The first expiry falls on the Nth rising edge after the edge that first samples the code, and later expiries follow every N edges.
- R4: Rate code 2'b10 sets an interval of floor(15600 × CLK_MHZ / 1000) cycles (15.6 µs), with the same timing as R3.
- R5: Rate code 2'b11 sets an interval of floor(125000 × CLK_MHZ / 1000) cycles (125 µs), with the same timing as R3.
- R6: When the sampled rate code changes, the interval count starts again from zero. The count already reached under the old code is dropped.
- R7: Each expiry adds one to `pend_cnt`. The count saturates at PEND_MAX (default 8).
- R8: An acknowledge with a nonzero count removes exactly one from `pend_cnt`. An acknowledge when the count is 0 is ignored, and the count stays at 0.
- R9: If an expiry and an accepted acknowledge fall on the same edge, `pend_cnt` is unchanged.
- R10: `refresh_req` is high exactly when `pend_cnt` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, same as the memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Refresh rate code: 00 off, 01 7.8 µs, 10 15.6 µs, 11 125 µs |
| refresh_ack | input | 1 | Controller has issued one refresh (one pulse per refresh) |
| refresh_req | output | 1 | High while refreshes are owed |
| pend_cnt | output | $clog2(PEND_MAX+1) | Number of refreshes owed |

## Verification
Reset clears the outputs at once. The bench samples them at the falling edge that follows. A new rate code is taken on the first rising edge after it is driven. From that edge, the request rises on the Nth edge and is visible at the next falling edge. The bench counts N−1 edges and expects the request to be low, then counts one more edge and expects it to be high. An acknowledge takes effect on the single edge it spans, and a tick lined up with an acknowledge is placed on the exact Nth edge. The bench computes every interval from the rate code and CLK_MHZ and never reads internal state.

// File: rtl/refresh_timer_pkg.sv
package refresh_timer_pkg;

  // Refresh intervals in nanoseconds
  localparam int unsigned FAST_NS = 7800;
  localparam int unsigned SLOW_NS = 15600;
  localparam int unsigned LONG_NS = 125000;

  typedef enum logic [1:0] {
    RATE_OFF  = 2'b00,
    RATE_FAST = 2'b01,
    RATE_SLOW = 2'b10,
    RATE_LONG = 2'b11
  } rate_e;

  // Interval in whole clock cycles: interval x frequency, rounded down
  function automatic int unsigned interval_cycles(input logic [1:0] code,
                                                  input int unsigned mhz);
    case (rate_e'(code))
      RATE_FAST: return (FAST_NS * mhz) / 1000;
      RATE_SLOW: return (SLOW_NS * mhz) / 1000;
      RATE_LONG: return (LONG_NS * mhz) / 1000;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/refresh_rate_decode.sv
module refresh_rate_decode import refresh_timer_pkg::*; #(
  parameter int unsigned CLK_MHZ = 133,
  parameter int unsigned CNT_W   = 15
) (
  input  logic [1:0]       rate_sel,
  output logic [CNT_W-1:0] ival_limit,
  output logic             ival_en
);

  localparam int unsigned NUM_CODES = 4;

  logic [CNT_W-1:0] limit_tbl [NUM_CODES];

  // One table entry per rate code, worked out when the design elaborates
  for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
    localparam int unsigned CYC = interval_cycles(2'(c), CLK_MHZ);
    assign limit_tbl[c] = CNT_W'(CYC);
  end

  assign ival_limit = limit_tbl[rate_sel];
  assign ival_en    = (rate_e'(rate_sel) != RATE_OFF);

endmodule

// File: rtl/refresh_interval_ctr.sv
module refresh_interval_ctr #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rate_sel,
  input  logic [CNT_W-1:0] ival_limit,
  input  logic             ival_en,
  output logic             tick_evt,
  output logic             rate_chg,
  output logic [CNT_W-1:0] ival_cnt
);

  logic [1:0]       rate_q;
  logic [CNT_W-1:0] last_cnt;
  logic             at_last;

  assign rate_chg = (rate_sel != rate_q);
  assign last_cnt = ival_limit - CNT_W'(1);
  assign at_last  = (ival_cnt == last_cnt);
  assign tick_evt = ival_en && !rate_chg && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q   <= 2'b00;
      ival_cnt <= '0;
    end else begin
      rate_q <= rate_sel;
      if (rate_chg || !ival_en || at_last) begin
        ival_cnt <= '0;
      end else begin
        ival_cnt <= ival_cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/refresh_pending_ctr.sv
module refresh_pending_ctr #(
  parameter int unsigned PEND_MAX = 8,
  parameter int unsigned PEND_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_evt,
  input  logic              refresh_ack,
  output logic [PEND_W-1:0] pend_cnt
);

  localparam int unsigned SUM_W = PEND_W + 1;

  // Add one per expiry, take one per accepted acknowledge, clamp at the ceiling
  function automatic logic [PEND_W-1:0] next_pend(input logic [PEND_W-1:0] cur,
                                                  input logic              inc,
                                                  input logic              dec);
    logic [SUM_W-1:0] sum;
    logic             take;
    take = dec && (cur != '0);
    sum  = {1'b0, cur} + SUM_W'(inc) - SUM_W'(take);
    if (sum > SUM_W'(PEND_MAX)) begin
      sum = SUM_W'(PEND_MAX);
    end
    return sum[PEND_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cnt <= '0;
    end else begin
      pend_cnt <= next_pend(pend_cnt, tick_evt, refresh_ack);
    end
  end

endmodule

// File: rtl/refresh_timer.sv
module refresh_timer import refresh_timer_pkg::*; #(
  parameter  int unsigned CLK_MHZ  = 133,
  parameter  int unsigned PEND_MAX = 8,
  localparam int unsigned PEND_W   = $clog2(PEND_MAX + 1),
  localparam int unsigned CNT_W    = $clog2(interval_cycles(2'b11, CLK_MHZ) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rate_sel,
  input  logic              refresh_ack,
  output logic              refresh_req,
  output logic [PEND_W-1:0] pend_cnt
);

  logic [CNT_W-1:0] ival_limit;
  logic             ival_en;
  logic             tick_evt;
  logic             rate_chg;
  logic [CNT_W-1:0] ival_cnt;

  refresh_rate_decode #(
    .CLK_MHZ (CLK_MHZ),
    .CNT_W   (CNT_W)
  ) u_decode (
    .rate_sel   (rate_sel),
    .ival_limit (ival_limit),
    .ival_en    (ival_en)
  );

  refresh_interval_ctr #(
    .CNT_W (CNT_W)
  ) u_interval (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate_sel   (rate_sel),
    .ival_limit (ival_limit),
    .ival_en    (ival_en),
    .tick_evt   (tick_evt),
    .rate_chg   (rate_chg),
    .ival_cnt   (ival_cnt)
  );

  refresh_pending_ctr #(
    .PEND_MAX (PEND_MAX),
    .PEND_W   (PEND_W)
  ) u_pending (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_evt    (tick_evt),
    .refresh_ack (refresh_ack),
    .pend_cnt    (pend_cnt)
  );

  assign refresh_req = (pend_cnt != '0);

endmodule

// File: rtl/refresh_timer_chk.sv
module refresh_timer_chk import refresh_timer_pkg::*; #(
  parameter int unsigned CLK_MHZ  = 133,
  parameter int unsigned PEND_MAX = 8,
  parameter int unsigned PEND_W   = 4,
  parameter int unsigned CNT_W    = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        rate_sel,
  input logic              refresh_ack,
  input logic              refresh_req,
  input logic [PEND_W-1:0] pend_cnt,
  input logic              tick_evt,
  input logic              rate_chg,
  input logic [CNT_W-1:0]  ival_cnt
);

  // Cycles since the last restart or expiry, kept apart from the design's counter
  logic [31:0] gap_q;
  logic [31:0] exp_cyc;

  assign exp_cyc = interval_cycles(rate_sel, CLK_MHZ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (rate_chg || tick_evt) begin
      gap_q <= '0;
    end else if (gap_q != 32'hFFFF_FFFF) begin
      gap_q <= gap_q + 32'd1;
    end
  end

  // R2
  off_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 2'b00) |-> !tick_evt);

  // R3, R4, R5
  interval_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt |-> (gap_q == exp_cyc - 32'd1));

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_chg |=> (ival_cnt == '0));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= PEND_W'(PEND_MAX));

  // R7
  tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_evt && !refresh_ack && (pend_cnt < PEND_W'(PEND_MAX)))
      |=> (pend_cnt == $past(pend_cnt) + PEND_W'(1)));

  // R8
  ack_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_ack && !tick_evt && (pend_cnt != '0))
      |=> (pend_cnt == $past(pend_cnt) - PEND_W'(1)));

  // R8
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_ack && !tick_evt && (pend_cnt == '0)) |=> (pend_cnt == '0));

  // R9
  both_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_evt && refresh_ack && (pend_cnt != '0)) |=> $stable(pend_cnt));

  // R10
  req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_req) |-> $past(tick_evt));

endmodule

bind refresh_timer refresh_timer_chk #(
  .CLK_MHZ  (CLK_MHZ),
  .PEND_MAX (PEND_MAX),
  .PEND_W   (PEND_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rate_sel    (rate_sel),
  .refresh_ack (refresh_ack),
  .refresh_req (refresh_req),
  .pend_cnt    (pend_cnt),
  .tick_evt    (tick_evt),
  .rate_chg    (rate_chg),
  .ival_cnt    (ival_cnt)
);

// File: tb/test_refresh_timer.sv
`timescale 1ns/1ps
module test_refresh_timer;

  localparam int MHZ   = 133;
  localparam int N_FST = (7800 * MHZ) / 1000;
  localparam int N_SLW = (15600 * MHZ) / 1000;
  localparam int N_LNG = (125000 * MHZ) / 1000;
  localparam int SAT   = 8;
  localparam int OFF_WAIT = 20000;

  localparam int VEC_N = 4;
  localparam logic [1:0] VEC_RATE [VEC_N] = '{2'b01, 2'b10, 2'b00, 2'b11};
  localparam int         VEC_CYC  [VEC_N] = '{N_FST, N_SLW, 0, N_LNG};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       refresh_ack = 1'b0;
  logic       refresh_req;
  logic [3:0] pend_cnt;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  refresh_timer i_refresh_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_sel    (rate_sel),
    .refresh_ack (refresh_ack),
    .refresh_req (refresh_req),
    .pend_cnt    (pend_cnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ack_pulses(input int n);
    refresh_ack = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    refresh_ack = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 req in reset", int'(refresh_req), 0);
    chk("R1 pend in reset", int'(pend_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pend after release", int'(pend_cnt), 0);

    // Table walk: first expiry at N, second at 2N (R2 R3 R4 R5, R10)
    for (int v = 0; v < VEC_N; v++) begin
      @(negedge clk);
      rate_sel = VEC_RATE[v];
      @(posedge clk);
      if (VEC_CYC[v] == 0) begin
        repeat (OFF_WAIT) @(posedge clk);
        @(negedge clk);
        chk("R2 no request when off", int'(refresh_req), 0);
        chk("R2 pend when off", int'(pend_cnt), 0);
      end else begin
        repeat (VEC_CYC[v] - 1) @(posedge clk);
        @(negedge clk);
        chk($sformatf("R%0d before first expiry", v == 0 ? 3 : (v == 1 ? 4 : 5)),
            int'(refresh_req), 0);
        @(posedge clk);
        @(negedge clk);
        chk($sformatf("R%0d first expiry", v == 0 ? 3 : (v == 1 ? 4 : 5)),
            int'(refresh_req), 1);
        chk("R10 pend at first expiry", int'(pend_cnt), 1);
        refresh_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        refresh_ack = 1'b0;
        chk("R8 ack clears one", int'(pend_cnt), 0);
        chk("R10 req low at zero", int'(refresh_req), 0);
        repeat (VEC_CYC[v] - 2) @(posedge clk);
        @(negedge clk);
        chk("R3 R4 R5 before second expiry", int'(refresh_req), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R3 R4 R5 second expiry", int'(refresh_req), 1);
        ack_pulses(1);
      end
    end

    // R6 restart on code change
    rate_sel = 2'b01;
    @(posedge clk);
    repeat (600) @(posedge clk);
    @(negedge clk);
    rate_sel = 2'b10;
    @(posedge clk);
    repeat (N_SLW - 1) @(posedge clk);
    @(negedge clk);
    chk("R6 no early expiry after change", int'(refresh_req), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R6 expiry one interval after change", int'(refresh_req), 1);
    ack_pulses(1);
    chk("R6 drained", int'(pend_cnt), 0);

    // R7 accumulation and saturation
    rate_sel = 2'b01;
    @(posedge clk);
    for (int k = 1; k <= 10; k++) begin
      repeat (N_FST) @(posedge clk);
      @(negedge clk);
      if (k == 3) chk("R7 three missed", int'(pend_cnt), 3);
    end
    chk("R7 saturated", int'(pend_cnt), SAT);
    chk("R10 req while owed", int'(refresh_req), 1);

    // R8 single acknowledge with refresh off
    rate_sel = 2'b00;
    ack_pulses(1);
    chk("R8 one ack", int'(pend_cnt), SAT - 1);
    ack_pulses(5);
    chk("R8 five acks", int'(pend_cnt), 2);

    // R9 expiry and acknowledge on the same edge
    rate_sel = 2'b01;
    @(posedge clk);
    repeat (N_FST - 1) @(posedge clk);
    @(negedge clk);
    refresh_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    refresh_ack = 1'b0;
    chk("R9 tick with ack", int'(pend_cnt), 2);

    // R1 reset while refreshes are owed
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears pend", int'(pend_cnt), 0);
    chk("R1 reset clears req", int'(refresh_req), 0);
    rate_sel = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;

    // R8 acknowledge at zero is ignored
    ack_pulses(3);
    chk("R8 ack at zero", int'(pend_cnt), 0);
    chk("R10 req after idle ack", int'(refresh_req), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule